// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block places the framing conditions of an I2C transaction on an open-drain bus: START, repeated START and STOP. It never drives a line high. Each line has one enable output, and an asserted enable pulls that line low. A deasserted enable leaves the line to the external pull-up. The block reads both lines back through a small synchronizer and uses them for two checks: whether another master has taken SDA, and whether SCL is held low by some other device.

A byte engine shares the bus with this block and follows a fixed handover contract. Between conditions, the bus rests either with both lines released and high (idle), or with both enables asserted (low-low). START is issued from idle and leaves the bus low-low. Repeated START and STOP are issued from low-low. Repeated START leaves the bus low-low, and STOP leaves it idle. One timing parameter sets the half period of the bus clock in core clock cycles.

A command enters on a valid/ready pair. `cmd_ready` is high only while the sequencer is idle, and a command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. While a condition is in progress, `cmd_ready` stays low, so a held command waits; it is neither queued nor lost. When a condition ends, `done` pulses for one cycle and `status` gives the outcome. `status` keeps that value until the next `done`.

Top module: `i2c_cond_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both enables are deasserted, `cmd_ready` is 1, `done` is 0 and `status` is 2'b00.
- R2: `cmd_ready` is 1 exactly when no condition is in progress. A command is taken only when `cmd_valid` and `cmd_ready` are both 1, and `cmd_valid` has no effect while `cmd_ready` is 0. Command codes are 2'b01 START, 2'b10 repeated START and 2'b11 STOP. Code 2'b00 is accepted and does nothing: no `done`, and neither enable changes.
- R3: START spends one cycle checking the synchronized lines. If SCL reads low, the block reports status 2'b01 (clock held low). Otherwise, if SDA reads low, it reports status 2'b10 (arbitration lost). When both read low, the clock check wins.
- R4: A START that passes its checks asserts `sda_oe` on the cycle after the check. It asserts `scl_oe` HALF_CYCLES cycles later, in the same cycle as `done` with status 2'b00.
- R5: Repeated START deasserts `sda_oe` on the cycle after it is accepted. It deasserts `scl_oe` HALF_CYCLES cycles later. After another HALF_CYCLES cycles it runs the full START of R3 and R4, including both checks.
- R6: STOP holds both enables unchanged for HALF_CYCLES cycles after it is accepted. It then deasserts `scl_oe` and asserts `sda_oe`. After HALF_CYCLES more cycles it deasserts `sda_oe`, and after another HALF_CYCLES cycles it gives `done`.
- R7: At the end of STOP, if SDA reads low, the status is 2'b10. Otherwise the status is 2'b00 and both lines are left released.
- R8: On any error, the block deasserts both enables in the same cycle as `done` and returns to idle. `status` changes only in a cycle where `done` is 1.
- R9: `done` is high for exactly one cycle per completed START, repeated START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, can take a command |
| cmd | input | 2 | Condition code (see R2) |
| done | output | 1 | One-cycle pulse when a condition ends |
| status | output | 2 | Outcome of the last condition: 00 ok, 01 clock held low, 10 arbitration lost |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two things can happen in the same cycle. A START check can find both faults at once, with SCL held low and SDA taken by another master. Separately, a new command can be offered in the very cycle that the previous condition's `done` returns the block to idle. The bench provokes the first by forcing both modelled bus lines low before a START, and expects the clock fault code. It provokes the second by holding `cmd_valid` high with a STOP code for the whole of a condition, and expects the STOP to be ignored until `cmd_ready` rises. A behavioural model of the open-drain bus and of the sequencer's timeline predicts every output on every clock.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_START   = 2'b01,
    CMD_RESTART = 2'b10,
    CMD_STOP    = 2'b11
  } cond_cmd_e;

  typedef enum logic [1:0] {
    STS_OK        = 2'b00,
    STS_SCL_STUCK = 2'b01,
    STS_ARB_LOST  = 2'b10
  } cond_sts_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHECK,
    PH_HOLD,
    PH_RS_SDA,
    PH_RS_SCL,
    PH_SP_LEAD,
    PH_SP_SCL,
    PH_SP_SDA
  } cond_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= raw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign synced = pipe[STAGES-1];

endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic lapse
);

  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;

  assign lapse = (cnt == CW'(HALF - 1));

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int HALF_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd,
  output logic       done,
  output logic [1:0] status,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  import i2c_cond_pkg::*;

  cond_phase_e phase;
  logic [1:0]  lines_s;
  logic        scl_s, sda_s;
  logic        lapse, tmr_clear;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  assign tmr_clear = (phase == PH_IDLE) || (phase == PH_CHECK) || lapse;

  i2c_half_timer #(.HALF(HALF_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .lapse(lapse)
  );

  assign cmd_ready = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      status <= STS_OK;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (cmd_valid) begin
          unique case (cond_cmd_e'(cmd))
            CMD_START:   phase <= PH_CHECK;
            CMD_RESTART: begin sda_oe <= 1'b0; phase <= PH_RS_SDA; end
            CMD_STOP:    phase <= PH_SP_LEAD;
            default:     phase <= PH_IDLE;
          endcase
        end
        PH_CHECK: begin
          if (!scl_s || !sda_s) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            done   <= 1'b1;
            status <= !scl_s ? STS_SCL_STUCK : STS_ARB_LOST;
            phase  <= PH_IDLE;
          end else begin
            sda_oe <= 1'b1;
            phase  <= PH_HOLD;
          end
        end
        PH_HOLD: if (lapse) begin
          scl_oe <= 1'b1;
          done   <= 1'b1;
          status <= STS_OK;
          phase  <= PH_IDLE;
        end
        PH_RS_SDA: if (lapse) begin
          scl_oe <= 1'b0;
          phase  <= PH_RS_SCL;
        end
        PH_RS_SCL: if (lapse) phase <= PH_CHECK;
        PH_SP_LEAD: if (lapse) begin
          sda_oe <= 1'b1;
          scl_oe <= 1'b0;
          phase  <= PH_SP_SCL;
        end
        PH_SP_SCL: if (lapse) begin
          sda_oe <= 1'b0;
          phase  <= PH_SP_SDA;
        end
        PH_SP_SDA: if (lapse) begin
          done   <= 1'b1;
          status <= sda_s ? STS_OK : STS_ARB_LOST;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd,
  input logic       done,
  input logic [1:0] status,
  input logic       scl_oe,
  input logic       sda_oe
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R2

  AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'b00) |-> (!scl_oe && !sda_oe)); // R8

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status)); // R8

  AST_SCL_PULL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (sda_oe && done)); // R4

  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd == 2'b00) |=> (cmd_ready && !done)); // R2

endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd(cmd), .done(done), .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic cmd_ready, done, scl_oe, sda_oe;
  logic [1:0] status;
  logic f_scl = 1'b0, f_sda = 1'b0;
  logic scl_line, sda_line;

  always #5 clk = ~clk;

  assign scl_line = !scl_oe && !f_scl;
  assign sda_line = !sda_oe && !f_sda;

  i2c_cond_gen #(.HALF_CYCLES(HALF), .SYNC_STAGES(2)) i_i2c_cond_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd(cmd), .done(done), .status(status), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int vectors = 0, errors = 0;
  bit finished = 0;
  string req = "R1";
  logic m_scl = 0, m_sda = 0;
  logic [1:0] m_sts = 2'b00;
  logic [5:0] expq [$];

  // packed item: {ready, done, status[1:0], scl_oe, sda_oe}
  task automatic push(int n, logic s, logic d, logic dn, logic [1:0] st, logic rdy);
    for (int i = 0; i < n; i++) expq.push_back({rdy, dn, st, s, d});
  endtask

  task automatic compare(logic [5:0] exp);
    logic [5:0] act;
    act = {cmd_ready, done, status, scl_oe, sda_oe};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t act{rdy,done,sts,scl_oe,sda_oe}=%b exp=%b", req, $time, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      compare({1'b1, 1'b0, m_sts, m_scl, m_sda});
    end
  endtask

  task automatic plan_start();
    logic sl, dl;
    push(1, m_scl, m_sda, 0, m_sts, 0);
    sl = !m_scl && !f_scl;
    dl = !m_sda && !f_sda;
    if (!sl || !dl) begin  // R3: clock fault has precedence
      m_sts = !sl ? 2'b01 : 2'b10;
      m_scl = 0; m_sda = 0;
      push(1, 0, 0, 1, m_sts, 1);
    end else begin          // R4
      push(HALF, m_scl, 1, 0, m_sts, 0);
      m_scl = 1; m_sda = 1; m_sts = 2'b00;
      push(1, 1, 1, 1, m_sts, 1);
    end
  endtask

  task automatic plan_restart();  // R5
    push(HALF, m_scl, 0, 0, m_sts, 0);
    m_sda = 0;
    push(HALF, 0, 0, 0, m_sts, 0);
    m_scl = 0;
    plan_start();
  endtask

  task automatic plan_stop();  // R6, R7
    push(HALF, m_scl, m_sda, 0, m_sts, 0);
    push(HALF, 0, 1, 0, m_sts, 0);
    push(HALF, 0, 0, 0, m_sts, 0);
    m_scl = 0; m_sda = 0;
    m_sts = f_sda ? 2'b10 : 2'b00;
    push(1, 0, 0, 1, m_sts, 1);
  endtask

  task automatic issue(string r, logic [1:0] c, logic fs, logic fd, bit pester);
    req = r;
    f_scl = fs; f_sda = fd;
    idle(4);
    cmd_valid = 1'b1; cmd = c;
    case (c)
      2'b01: plan_start();
      2'b10: plan_restart();
      2'b11: plan_stop();
      default: push(1, m_scl, m_sda, 0, m_sts, 1);
    endcase
    while (expq.size() > 0) begin
      @(posedge clk); @(negedge clk);
      compare(expq.pop_front());
      if (pester) cmd = 2'b11; else cmd_valid = 1'b0;
      if (expq.size() == 0) cmd_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired in %s", req);
    finish_run();
  end

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    compare({1'b1, 1'b0, 2'b00, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare({1'b1, 1'b0, 2'b00, 1'b0, 1'b0});
    issue("R4", 2'b01, 0, 0, 0);   // clean START
    issue("R6", 2'b11, 0, 0, 0);   // clean STOP
    issue("R2", 2'b01, 0, 0, 1);   // START with a STOP held during busy
    issue("R5", 2'b10, 0, 0, 1);   // repeated START, held STOP ignored
    issue("R7", 2'b11, 0, 0, 0);   // STOP ok
    issue("R2", 2'b00, 0, 0, 0);   // no-op code
    issue("R3", 2'b01, 0, 1, 0);   // SDA taken: arbitration lost
    issue("R8", 2'b00, 0, 0, 0);   // status held
    issue("R3", 2'b01, 1, 1, 0);   // both low: clock fault wins
    issue("R9", 2'b01, 0, 0, 0);   // START ok again, status cleared
    issue("R7", 2'b11, 0, 1, 0);   // STOP with SDA held low
    issue("R4", 2'b01, 0, 0, 0);
    issue("R5", 2'b10, 1, 0, 0);   // repeated START, clock held low
    issue("R8", 2'b01, 0, 0, 0);
    issue("R5", 2'b10, 0, 0, 0);
    issue("R6", 2'b11, 0, 0, 0);
    req = "R8";
    idle(4);
    finish_run();
  end

endmodule